// File: doc/BRIEF.md
# Binary XNOR-Popcount Dot Product Unit

This block forms the dot product of two binarized vectors, one of weights and one of activations, without any multiplier in the datapath. Each element is a single bit: a 1 stands for +1 and a 0 stands for -1. The vectors arrive as packed 32-bit words over a valid/last stream. On each accepted beat the block XNORs the weight word with the activation word, masks off positions past the programmed vector length, counts the surviving ones and adds the count to a running total.

On the beat marked last, the total match count `P` over the `N` valid elements becomes the signed dot product `2P - N`. That value is multiplied by two unsigned Q8.8 scale factors, one for the weights and one for the activations. The dot product and the scaled result are both presented for one cycle. A small controller with two named states sequences the work. `S_IDLE` waits for the first beat of a vector. `S_ACCUM` is in the middle of a multi-word vector. The transitions are: `start` (S_IDLE to S_ACCUM on a beat that is not last), `single` (S_IDLE to S_IDLE on a beat that is last), `more` (S_ACCUM to S_ACCUM on a beat that is not last), `finish` (S_ACCUM to S_IDLE on a last beat) and `hold` (either state unchanged while no beat arrives).

Top module: `bxp_dot_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `out_valid` is 0 and the controller is in `S_IDLE`.
- R2: A 1 bit encodes +1 and a 0 bit encodes -1. The per-element product is the XNOR of the weight and activation bits. `out_dot` equals the sum of these ±1 products over the first N elements, which is 2·(matches) − N.
- R3: Element k of a vector sits in bit k mod 32 of the beat numbered k/32, counting beats from 0 in arrival order and bits from bit 0.
- R4: Elements with index ≥ `vec_len` do not count, including whole beats that lie beyond it. With `vec_len` = 0 the dot product is 0. `vec_len` must be held steady for the whole vector.
- R5: The first beat after reset, and the first beat after any last beat, starts a fresh total. Nothing from the previous vector carries over.
- R6: `out_valid` is high for exactly the one cycle after the clock edge that accepts a last beat. `out_dot` and `out_result` keep their values until the next result.
- R7: Cycles with `in_valid` low are ignored, so gaps between the beats of a vector do not change the result.
- R8: `alpha` and `beta` are unsigned Q8.8 values, sampled on the last beat. `out_result` holds the low `OUT_W` bits of `out_dot · alpha · beta` in two's complement, with 16 fraction bits.
- R9: Single-beat vectors sent on back-to-back cycles each produce their own result pulse, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A beat is offered this cycle |
| in_last | input | 1 | This beat closes the vector |
| in_wgt | input | 32 | Packed weight bits |
| in_act | input | 32 | Packed activation bits |
| vec_len | input | LEN_W (12) | Number of valid elements N in the vector |
| alpha | input | SCALE_W (16) | Weight scale, unsigned Q8.8 |
| beta | input | SCALE_W (16) | Activation scale, unsigned Q8.8 |
| out_valid | output | 1 | One-cycle result strobe |
| out_dot | output | LEN_W+2 (14) | Signed ±1 dot product |
| out_result | output | OUT_W (48) | Scaled dot product, signed, 16 fraction bits |

## Verification
Equal and complementary words tell the positive and negative extremes apart. A vector in which only bit 0 disagrees, with lengths 1 and 32, shows whether the element order and the encoding are right. Lengths of 0, of a part word and of runs that end before the final beats probe the masking. Back-to-back single-beat vectors, gaps inside a vector and a new vector right after a finished one separate the clearing of the total from its accumulation. Random multi-word vectors with random lengths and scales are compared on every clock with an element-by-element ±1 sum kept in the bench.

// File: rtl/bxp_pkg.sv
package bxp_pkg;
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_ACCUM = 1'b1
    } bxp_state_e;
endpackage

// File: rtl/bxp_lane_mask.sv
// Marks the bit positions of the current beat that fall below the vector length.
module bxp_lane_mask #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12,
    parameter int IDX_W  = LEN_W - $clog2(WORD_W) + 1
) (
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [LEN_W-1:0]  vec_len,
    output logic [WORD_W-1:0] lane_en
);
    localparam int LOG_W  = $clog2(WORD_W);
    localparam int BASE_W = IDX_W + LOG_W;

    logic [BASE_W-1:0] base;
    logic [BASE_W-1:0] limit;

    assign base  = {word_idx, {LOG_W{1'b0}}};
    assign limit = BASE_W'(vec_len);

    for (genvar b = 0; b < WORD_W; b++) begin : g_lane
        assign lane_en[b] = (base + BASE_W'(b)) < limit;
    end
endmodule

// File: rtl/bxp_popcount.sv
// Counts the ones in one masked XNOR word.
module bxp_popcount #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] bits,
    output logic [CNT_W-1:0]  count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < WORD_W; i++) begin
            count = count + CNT_W'(bits[i]);
        end
    end
endmodule

// File: rtl/bxp_ctrl.sv
// Vector sequencer: tracks the beat index and the running match total.
module bxp_ctrl
    import bxp_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12,
    parameter int CNT_W  = $clog2(WORD_W + 1),
    parameter int IDX_W  = LEN_W - $clog2(WORD_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [CNT_W-1:0] beat_count,
    input  logic [LEN_W-1:0] vec_len,
    output logic [IDX_W-1:0] word_idx,
    output logic             fire,
    output logic [LEN_W-1:0] total
);
    bxp_state_e state_q, state_d;
    logic [LEN_W-1:0] acc_q;
    logic [IDX_W-1:0] idx_q;
    logic             first_beat;
    logic [LEN_W-1:0] acc_base;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (in_valid && !in_last) state_d = S_ACCUM;
            S_ACCUM: if (in_valid && in_last)  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register with beat index and running total
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            acc_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                acc_q <= total;
                if (in_last) begin
                    idx_q <= '0;
                end else if (word_idx != {IDX_W{1'b1}}) begin
                    idx_q <= word_idx + 1'b1;
                end else begin
                    idx_q <= word_idx;
                end
            end
        end
    end

    // outputs
    always_comb begin
        first_beat = (state_q == S_IDLE);
        acc_base   = first_beat ? '0 : acc_q;
        word_idx   = first_beat ? '0 : idx_q;
        total      = acc_base + LEN_W'(beat_count);
        fire       = in_valid && in_last;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> state_q == S_IDLE);

    a_r5_total_within_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACCUM) |-> (acc_q <= vec_len));

    a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> (state_q == S_IDLE));
endmodule

// File: rtl/bxp_scaler.sv
// Turns the match total into a signed dot product and applies both scales.
module bxp_scaler #(
    parameter int LEN_W   = 12,
    parameter int SCALE_W = 16,
    parameter int OUT_W   = 48,
    parameter int DOT_W   = LEN_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic [LEN_W-1:0]        total,
    input  logic [LEN_W-1:0]        vec_len,
    input  logic [SCALE_W-1:0]      alpha,
    input  logic [SCALE_W-1:0]      beta,
    output logic                    out_valid,
    output logic signed [DOT_W-1:0] out_dot,
    output logic [OUT_W-1:0]        out_result
);
    localparam int SC_W = 2 * SCALE_W;

    logic signed [DOT_W-1:0] dot_c;
    logic [SC_W-1:0]         scale_c;
    logic [OUT_W-1:0]        dot_x;
    logic [OUT_W-1:0]        prod_c;

    always_comb begin
        dot_c   = $signed({1'b0, total, 1'b0}) - $signed({2'b00, vec_len});
        scale_c = alpha * beta;
        dot_x   = OUT_W'(dot_c);
        prod_c  = dot_x * OUT_W'(scale_c);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_dot    <= '0;
            out_result <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_dot    <= dot_c;
                out_result <= prod_c;
            end
        end
    end

    a_r2_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_dot[0] == $past(vec_len[0])));

    a_r8_zero_dot: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dot == '0) |-> (out_result == '0));
endmodule

// File: rtl/bxp_dot_unit.sv
module bxp_dot_unit #(
    parameter int WORD_W  = 32,
    parameter int LEN_W   = 12,
    parameter int SCALE_W = 16,
    parameter int OUT_W   = 48
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_last,
    input  logic [WORD_W-1:0]         in_wgt,
    input  logic [WORD_W-1:0]         in_act,
    input  logic [LEN_W-1:0]          vec_len,
    input  logic [SCALE_W-1:0]        alpha,
    input  logic [SCALE_W-1:0]        beta,
    output logic                      out_valid,
    output logic signed [LEN_W+1:0]   out_dot,
    output logic [OUT_W-1:0]          out_result
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int IDX_W = LEN_W - $clog2(WORD_W) + 1;
    localparam int DOT_W = LEN_W + 2;

    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] lane_en;
    logic [WORD_W-1:0] agree;
    logic [CNT_W-1:0]  beat_count;
    logic              fire;
    logic [LEN_W-1:0]  total;

    bxp_lane_mask #(.WORD_W(WORD_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_mask (
        .word_idx (word_idx),
        .vec_len  (vec_len),
        .lane_en  (lane_en)
    );

    assign agree = ~(in_wgt ^ in_act) & lane_en;

    bxp_popcount #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_pop (
        .bits  (agree),
        .count (beat_count)
    );

    bxp_ctrl #(.WORD_W(WORD_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .beat_count (beat_count),
        .vec_len    (vec_len),
        .word_idx   (word_idx),
        .fire       (fire),
        .total      (total)
    );

    bxp_scaler #(.LEN_W(LEN_W), .SCALE_W(SCALE_W), .OUT_W(OUT_W), .DOT_W(DOT_W)) u_scale (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .total      (total),
        .vec_len    (vec_len),
        .alpha      (alpha),
        .beta       (beta),
        .out_valid  (out_valid),
        .out_dot    (out_dot),
        .out_result (out_result)
    );

    a_r4_mask_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (int'(beat_count) <= $countones(lane_en)));

    a_r6_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_last));

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/bxp_dot_unit_test.sv
module bxp_dot_unit_test;
    localparam int LEN_W   = 12;
    localparam int SCALE_W = 16;
    localparam int OUT_W   = 48;
    localparam int DOT_W   = LEN_W + 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_last = 1'b0;
    logic [31:0]             in_wgt = '0;
    logic [31:0]             in_act = '0;
    logic [LEN_W-1:0]        vec_len = '0;
    logic [SCALE_W-1:0]      alpha = 16'd256;
    logic [SCALE_W-1:0]      beta = 16'd256;
    logic                    out_valid;
    logic signed [DOT_W-1:0] out_dot;
    logic [OUT_W-1:0]        out_result;

    int n_checks = 0;
    int n_fail = 0;

    bxp_dot_unit #(.WORD_W(32), .LEN_W(LEN_W), .SCALE_W(SCALE_W), .OUT_W(OUT_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_wgt(in_wgt), .in_act(in_act), .vec_len(vec_len), .alpha(alpha),
        .beta(beta), .out_valid(out_valid), .out_dot(out_dot), .out_result(out_result)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: element-by-element sum of ±1 products.
    int               m_sum = 0;
    int               m_words = 0;
    bit               m_busy = 1'b0;
    logic             e_valid = 1'b0;
    longint           e_dot = 0;
    logic [OUT_W-1:0] e_res = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy  = 1'b0;
            e_valid <= 1'b0;
        end else begin
            e_valid <= 1'b0;
            if (in_valid) begin
                if (!m_busy) begin
                    m_sum   = 0;
                    m_words = 0;
                end
                for (int b = 0; b < 32; b++) begin
                    if (m_words * 32 + b < int'(vec_len))
                        m_sum += (in_wgt[b] == in_act[b]) ? 1 : -1;
                end
                m_words++;
                m_busy = !in_last;
                if (in_last) begin
                    e_valid <= 1'b1;
                    e_dot   <= longint'(m_sum);
                    e_res   <= OUT_W'(longint'(m_sum) * longint'(alpha) * longint'(beta));
                end
            end
        end
    end

    // every-clock comparison against the reference (R2, R6, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            check(out_valid == e_valid, "R6 valid", longint'(out_valid), longint'(e_valid));
            if (out_valid && e_valid) begin
                check(longint'(out_dot) == e_dot, "R2 dot", longint'(out_dot), e_dot);
                check(out_result == e_res, "R8 result", longint'(out_result), longint'(e_res));
            end
        end
    end

    task automatic beat(input logic [31:0] w, input logic [31:0] a, input logic last);
        in_valid = 1'b1;
        in_last  = last;
        in_wgt   = w;
        in_act   = a;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input longint dot, input longint res);
        check(out_valid == 1'b1, {tag, " strobe"}, longint'(out_valid), 1);
        check(longint'(out_dot) == dot, {tag, " dot"}, longint'(out_dot), dot);
        check(out_result == OUT_W'(res), {tag, " result"}, longint'(out_result), res);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);

        // R2: all agree, unit scales -> +32, result 32 << 16
        vec_len = 12'd32; alpha = 16'd256; beta = 16'd256;
        beat(32'hA5C3_0F19, 32'hA5C3_0F19, 1'b1);
        expect_out("R2 all agree", 32, 32 * 65536);
        // R2 / R5: all disagree, fresh vector -> -32
        beat(32'h1234_5678, ~32'h1234_5678, 1'b1);
        expect_out("R5 fresh after last", -32, -32 * 65536);
        idle(1);

        // R3: only bit 0 disagrees
        vec_len = 12'd1;
        beat(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b1);
        expect_out("R3 element 0 is bit 0", -1, -65536);
        vec_len = 12'd32;
        beat(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b1);
        expect_out("R3 full word", 30, 30 * 65536);
        idle(1);

        // R4: zero length
        vec_len = 12'd0;
        beat(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        expect_out("R4 zero length", 0, 0);
        idle(1);

        // R4: length 40 over three beats; low 8 of beat 1 agree, beat 2 ignored
        vec_len = 12'd40;
        beat(32'h0F0F_0F0F, 32'h0F0F_0F0F, 1'b0);
        beat(32'h0000_00FF, 32'hFFFF_FF00 ^ 32'hFFFF_FFFF ^ 32'hFFFF_FF00 | 32'h0000_00FF, 1'b0);
        beat(32'h0000_0000, 32'hFFFF_FFFF, 1'b1);
        expect_out("R4 masked tail", 40, 40 * 65536);
        idle(1);

        // R7: gaps inside a vector
        vec_len = 12'd64;
        beat(32'h0000_0000, 32'h0000_0000, 1'b0);
        idle(3);
        beat(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1);
        expect_out("R7 gaps ignored", 64, 64 * 65536);

        // R9: back-to-back single-beat vectors; R6 one-cycle strobe and hold
        vec_len = 12'd32;
        beat(32'h0, 32'h0, 1'b1);
        in_valid = 1'b1; in_last = 1'b1; in_wgt = 32'h0; in_act = 32'hFFFF_FFFF;
        expect_out("R9 first pulse", 32, 32 * 65536);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        expect_out("R9 second pulse", -32, -32 * 65536);
        @(negedge clk);
        check(out_valid == 1'b0, "R6 strobe drops", longint'(out_valid), 0);
        check(longint'(out_dot) == -32, "R6 dot held", longint'(out_dot), -32);

        // R8: scales 1.5 and 2.0 on a dot of -3
        vec_len = 12'd3; alpha = 16'h0180; beta = 16'h0200;
        beat(32'h0, 32'h0000_0007, 1'b1);
        expect_out("R8 fractional scales", -3, -3 * 384 * 512);
        idle(1);

        // random vectors, lengths, scales and gaps (R2, R4, R7, R8)
        for (int v = 0; v < 120; v++) begin
            int nw;
            nw = 1 + ($urandom % 5);
            vec_len = LEN_W'($urandom % (nw * 32 + 1));
            alpha = SCALE_W'($urandom);
            beta  = SCALE_W'($urandom);
            for (int k = 0; k < nw; k++) begin
                beat($urandom, $urandom, k == nw - 1);
                if (k != nw - 1 && ($urandom % 3) == 0) idle(1 + ($urandom % 2));
            end
            if (($urandom % 2) == 0) idle(1);
        end
        idle(3);

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule